// File: doc/BRIEF.md
# Pipelined High-Word Signed Multiply-Accumulate

This block multiplies two signed 32-bit operands and returns only the upper 32 bits of a 64-bit intermediate value. It is meant for Q31 fixed-point arithmetic. A full-precision product is formed, and the high word is the useful Q31 result. An operation code selects one of three forms. The first is a bare multiply. The second adds the product to an accumulator word placed in the upper half. The third subtracts the product from that shifted accumulator. A separate round enable adds half an LSB of the output word, 2^31, to the 64-bit intermediate before truncation, which rounds the result to nearest.

The datapath has three register stages: operand capture, product, and combine/round. It accepts a new operation on every clock. Each result leaves exactly three cycles after it was presented, with a valid strobe that travels with it. There are no flags, no saturation and no low product word. All sums wrap modulo 2^64.

Top module: `hwmac_top`

## Requirements
- R1: In multiply mode (`in_op` = 2'b00, and also 2'b11), `out_result` is bits [63:32] of the signed 64-bit product `in_a * in_b`, plus 2^31 when `in_round` is 1.
- R2: In accumulate mode (`in_op` = 2'b01), `out_result` is bits [63:32] of `(in_acc << 32) + in_a*in_b`, plus 2^31 when rounding.
- R3: In subtract mode (`in_op` = 2'b10), `out_result` is bits [63:32] of `(in_acc << 32) - in_a*in_b`, plus 2^31 when rounding.
- R4: The rounding constant 2^31 is added to the full 64-bit intermediate, so a carry out of the low word propagates into the returned high word.
- R5: All arithmetic wraps modulo 2^64. No saturation takes place.
- R6: `out_valid` rises exactly three clock edges after the edge that sampled `in_valid` high, and `out_result` holds that operation's result in the same cycle.
- R7: One operation is accepted on every clock. Back-to-back inputs produce back-to-back results in issue order.
- R8: A cycle with `in_valid` low produces no `out_valid` three cycles later.
- R9: A synchronous active-high `rst` clears every stage's valid bit, so `out_valid` is 0 in the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 32 | Signed multiplicand |
| in_b | input | 32 | Signed multiplier |
| in_acc | input | 32 | Accumulator word, placed in the upper half |
| in_op | input | 2 | 00 multiply, 01 accumulate, 10 subtract, 11 multiply |
| in_round | input | 1 | Add 2^31 before truncation |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Upper 32 bits of the intermediate |

## Verification
The bench builds the block with its default 32-bit word width. At that width, real Q31 extremes can be applied directly. These include the most negative value squared, the product of 2^-31 with -1.0 where rounding carries from the low word into a zero high word, and accumulator sums that wrap past the signed range. Directed bursts with and without gaps test the fixed three-cycle latency and the result order for every operation code, including the spare code.

// File: rtl/hwmac_pkg.sv
package hwmac_pkg;
  typedef enum logic [1:0] {
    OP_MUL   = 2'b00,
    OP_ACC   = 2'b01,
    OP_SUB   = 2'b10,
    OP_MUL_2 = 2'b11
  } hw_op_e;
endpackage

// File: rtl/hwmac_capture.sv
module hwmac_capture #(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  v_in,
  input  logic [W-1:0]          a_in,
  input  logic [W-1:0]          b_in,
  input  logic [W-1:0]          acc_in,
  input  hwmac_pkg::hw_op_e     op_in,
  input  logic                  rnd_in,
  output logic                  v_q,
  output logic [W-1:0]          a_q,
  output logic [W-1:0]          b_q,
  output logic [W-1:0]          acc_q,
  output hwmac_pkg::hw_op_e     op_q,
  output logic                  rnd_q
);
  // only the valid bit is reset; data registers load freely
  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    a_q   <= a_in;
    b_q   <= b_in;
    acc_q <= acc_in;
    op_q  <= op_in;
    rnd_q <= rnd_in;
  end

  // R9: reset leaves the capture stage empty
  assert_capture_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> !v_q);
endmodule

// File: rtl/hwmac_product.sv
module hwmac_product #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  v_in,
  input  logic [W-1:0]          a_in,
  input  logic [W-1:0]          b_in,
  input  logic [W-1:0]          acc_in,
  input  hwmac_pkg::hw_op_e     op_in,
  input  logic                  rnd_in,
  output logic                  v_q,
  output logic [PW-1:0]         prod_q,
  output logic [W-1:0]          acc_q,
  output hwmac_pkg::hw_op_e     op_q,
  output logic                  rnd_q
);
  logic signed [PW-1:0] prod_d;

  always_comb prod_d = $signed(a_in) * $signed(b_in);

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    prod_q <= prod_d;
    acc_q  <= acc_in;
    op_q   <= op_in;
    rnd_q  <= rnd_in;
  end

  // R1: a zero operand must give an all-zero product word
  assert_zero_operand_R1: assert property (@(posedge clk) disable iff (rst)
    (v_in && (a_in == '0 || b_in == '0)) |=> (prod_q == '0));
endmodule

// File: rtl/hwmac_combine.sv
module hwmac_combine #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  v_in,
  input  logic [PW-1:0]         prod_in,
  input  logic [W-1:0]          acc_in,
  input  hwmac_pkg::hw_op_e     op_in,
  input  logic                  rnd_in,
  output logic                  v_q,
  output logic [W-1:0]          hi_q
);
  import hwmac_pkg::*;

  localparam logic [PW-1:0] HALF_LSB = PW'(1) << (W - 1);

  logic [PW-1:0] acc_wide;
  logic [PW-1:0] base;
  logic [PW-1:0] bias;
  logic [PW-1:0] total;

  always_comb begin
    acc_wide = {acc_in, {W{1'b0}}};
    unique case (op_in)
      OP_ACC:  base = acc_wide + prod_in;
      OP_SUB:  base = acc_wide - prod_in;
      default: base = prod_in;
    endcase
    bias  = rnd_in ? HALF_LSB : '0;
    total = base + bias;
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
  end

  always_ff @(posedge clk) hi_q <= total[PW-1:W];

  // R2: zero product with no rounding in accumulate mode returns the accumulator
  assert_acc_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    (v_in && op_in == OP_ACC && !rnd_in && prod_in == '0) |=> (hi_q == $past(acc_in)));
endmodule

// File: rtl/hwmac_top.sv
module hwmac_top #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [W-1:0]  in_acc,
  input  logic [1:0]    in_op,
  input  logic          in_round,
  output logic          out_valid,
  output logic [W-1:0]  out_result
);
  import hwmac_pkg::*;

  localparam int PW = 2 * W;

  logic              s1_v, s2_v;
  logic [W-1:0]      s1_a, s1_b, s1_acc, s2_acc;
  hw_op_e            s1_op, s2_op;
  logic              s1_rnd, s2_rnd;
  logic [PW-1:0]     s2_prod;
  hw_op_e            op_cast;

  always_comb op_cast = hw_op_e'(in_op);

  hwmac_capture #(.W(W)) u_capture (
    .clk(clk), .rst(rst),
    .v_in(in_valid), .a_in(in_a), .b_in(in_b), .acc_in(in_acc),
    .op_in(op_cast), .rnd_in(in_round),
    .v_q(s1_v), .a_q(s1_a), .b_q(s1_b), .acc_q(s1_acc),
    .op_q(s1_op), .rnd_q(s1_rnd)
  );

  hwmac_product #(.W(W)) u_product (
    .clk(clk), .rst(rst),
    .v_in(s1_v), .a_in(s1_a), .b_in(s1_b), .acc_in(s1_acc),
    .op_in(s1_op), .rnd_in(s1_rnd),
    .v_q(s2_v), .prod_q(s2_prod), .acc_q(s2_acc),
    .op_q(s2_op), .rnd_q(s2_rnd)
  );

  hwmac_combine #(.W(W)) u_combine (
    .clk(clk), .rst(rst),
    .v_in(s2_v), .prod_in(s2_prod), .acc_in(s2_acc),
    .op_in(s2_op), .rnd_in(s2_rnd),
    .v_q(out_valid), .hi_q(out_result)
  );

  // R6: an accepted operation emerges exactly three edges later
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && !rst, 3) && !$past(rst, 1) && !$past(rst, 2)) |-> out_valid);

  // R8: an idle slot stays idle at the output
  assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!in_valid, 3) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)) |-> !out_valid);

  // R9: no result in the cycle after a reset edge
  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R3: subtract of a zero product without rounding returns the accumulator
  assert_sub_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_op == 2'b10 && !in_round && in_a == '0, 3)
     && !$past(rst, 1) && !$past(rst, 2)) |-> (out_result == $past(in_acc, 3)));
endmodule

// File: tb/hwmac_top_bench.sv
module hwmac_top_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_a = '0, in_b = '0, in_acc = '0;
  logic [1:0]    in_op = 2'b00;
  logic          in_round = 1'b0;
  logic          out_valid;
  logic [W-1:0]  out_result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  int           stamp_q[$];
  string        tag_q[$];

  hwmac_top #(.W(W)) u_hwmac_top (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .in_op(in_op), .in_round(in_round),
    .out_valid(out_valid), .out_result(out_result)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [W-1:0] acc, input logic [1:0] op,
                                         input logic rnd);
    logic signed [2*W-1:0] p;
    logic [2*W-1:0] t;
    p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    if (op == 2'b01)      t = {acc, {W{1'b0}}} + p;
    else if (op == 2'b10) t = {acc, {W{1'b0}}} - p;
    else                  t = p;
    if (rnd) t = t + (64'd1 << 31);
    return t[2*W-1:W];
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor: order, value and three-cycle latency (R6, R7)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 spurious valid", out_result, '0);
        end else begin
          logic [W-1:0] e;
          int st;
          string tg;
          e = exp_q.pop_front();
          st = stamp_q.pop_front();
          tg = tag_q.pop_front();
          check(out_result == e, tg, out_result, e);
          check(cyc - st == 3, "R6 latency", W'(cyc - st), W'(3));
        end
      end
    end
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] acc,
                       input logic [1:0] op, input logic rnd, input string tg);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_acc = acc; in_op = op; in_round = rnd;
    exp_q.push_back(model(a, b, acc, op, rnd));
    stamp_q.push_back(cyc);
    tag_q.push_back(tg);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = 32'hDEAD_BEEF; in_b = 32'h1234_5678;
    end
  endtask

  task automatic drain(input string tg);
    idle(5);
    check(exp_q.size() == 0, tg, W'(exp_q.size()), '0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset state", W'(out_valid), '0);
  endtask

  task automatic t_multiply;
    issue(32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFF, 2'b00, 1'b0, "R1 small");
    issue(32'h8000_0000, 32'h8000_0000, '0, 2'b00, 1'b0, "R1 min squared");
    issue(32'h4000_0000, 32'hC000_0000, '0, 2'b00, 1'b0, "R1 half times neg half");
    issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, '0, 2'b11, 1'b0, "R1 spare code");
    issue(32'hFFFF_FFFF, 32'h0000_0001, '0, 2'b00, 1'b0, "R1 minus one lsb");
    drain("R1 drained");
  endtask

  task automatic t_rounding;
    issue(32'h0000_0001, 32'h8000_0000, '0, 2'b00, 1'b1, "R4 carry into zero");
    issue(32'h0000_0001, 32'h8000_0000, '0, 2'b00, 1'b0, "R4 no round");
    issue(32'h0001_0000, 32'h0000_8000, '0, 2'b00, 1'b1, "R4 exact half");
    issue(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0010, 2'b01, 1'b1, "R2 rounded acc");
    issue(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0010, 2'b10, 1'b1, "R3 rounded sub");
    drain("R4 drained");
  endtask

  task automatic t_accumulate;
    issue(32'h0000_0000, 32'h5555_5555, 32'hCAFE_F00D, 2'b01, 1'b0, "R2 zero product");
    issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b01, 1'b0, "R5 acc wrap");
    issue(32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 2'b01, 1'b0, "R2 borrow into high");
    issue(32'h8000_0000, 32'h8000_0000, 32'hC000_0000, 2'b01, 1'b0, "R2 cancel");
    drain("R2 drained");
  endtask

  task automatic t_subtract;
    issue(32'h0000_0000, 32'h1111_1111, 32'h0BAD_F00D, 2'b10, 1'b0, "R3 zero product");
    issue(32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 2'b10, 1'b0, "R3 tiny borrow");
    issue(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 2'b10, 1'b0, "R5 sub wrap");
    issue(32'h7654_3210, 32'hF0F0_F0F0, 32'h2222_2222, 2'b10, 1'b0, "R3 mixed");
    drain("R3 drained");
  endtask

  task automatic t_stream;
    for (int i = 0; i < 12; i++) begin
      issue(32'h1357_9BDF * (i + 1), 32'hFEDC_BA98 ^ (i * 32'h0101_0101),
            32'h0F0F_0000 + i, 2'(i), i[2], "R7 back to back");
    end
    drain("R7 drained");
  endtask

  task automatic t_gaps;
    issue(32'h0000_0100, 32'h0100_0000, '0, 2'b00, 1'b0, "R8 before gap");
    idle(2);
    issue(32'h0000_0200, 32'h0100_0000, '0, 2'b00, 1'b0, "R8 after gap");
    idle(1);
    issue(32'h0000_0300, 32'h0100_0000, 32'h0000_0001, 2'b01, 1'b0, "R8 after single gap");
    drain("R8 drained");
  endtask

  task automatic t_midreset;
    issue(32'h1111_1111, 32'h2222_2222, '0, 2'b00, 1'b0, "R9 flushed");
    issue(32'h3333_3333, 32'h4444_4444, '0, 2'b00, 1'b0, "R9 flushed");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    exp_q.delete(); stamp_q.delete(); tag_q.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R9 cleared in flight", W'(out_valid), '0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9 nothing after reset", W'(out_valid), '0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_multiply();
    t_rounding();
    t_accumulate();
    t_subtract();
    t_stream();
    t_gaps();
    t_midreset();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule